// File: doc/BRIEF.md
# Result Readback Pointer

This block is the read side of a small bank of conversion results. It holds a pointer into the result memory and drives the addressed result onto a tri-state data bus while a qualified read strobe is active. When the strobe is released, the pointer moves on to the next channel location that is enabled in the channel mask, in ascending order, and wraps back to the lowest enabled location after the highest. The memory array and the converter are outside the block: the pointer is presented on `mem_addr`, and the memory returns the word on `mem_rdata` in the same cycle.

The pointer is set again from the write side. A write that starts a multichannel conversion sends it back to the lowest enabled channel as soon as the write strobe goes active. A write whose configuration word carries the inhibit flag, or which asks for a single-channel conversion, loads the address field of that word into the pointer when the strobe is released. This allows random-access reads without starting a conversion. While power-down is set, nothing is read from the memory and no conversion can restart the pointer.

All strobes are active-low levels that are sampled on `clk`, and they are recognised only while `cs_n` is low.

Top module: `rp_readback_ptr`

## Requirements
- R1: While `cs_n`=0, `rd_n`=0 and `pd`=0, `dbus_oe` is 1 in that same cycle, `dbus` carries `mem_rdata`, and `mem_addr` equals the pointer.
- R2: One cycle after a qualified read strobe is released, the pointer moves to the next higher index whose bit is set in `chan_mask`.
- R3: When no enabled index lies above the pointer, the step wraps it to the lowest set bit of `chan_mask`.
- R4: When a write strobe becomes active with `cfg_multi`=1, `cfg_inhibit`=0 and `pd`=0, the pointer is set to the lowest set bit of `chan_mask` on the next clock. If the mask is all zero, it is set to 0.
- R5: When a write strobe is released with `cfg_inhibit`=1, the pointer takes `cfg_addr`, even if that location is not enabled. The next read returns that location, and later reads continue with the enabled locations above it.
- R6: When a write strobe is released with `cfg_multi`=0 (a single-channel conversion), the pointer takes `cfg_addr`. The first read returns that channel, and further reads return the other enabled locations in ascending order.
- R7: While `pd`=1, `dbus_oe` stays 0, read strobes do not move the pointer, and write strobes do not restart it. An inhibited address load is still accepted.
- R8: While `cs_n`=1, read and write strobes have no effect: the bus is not driven and the pointer does not change.
- R9: `dbus_oe` is 0 whenever the read strobe is inactive, and `mem_addr` stays constant for as long as a read strobe remains active.
- R10: After reset, the pointer is 0 and `dbus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| pd | input | 1 | Power-down flag from the configuration register |
| chan_mask | input | NCH | Enabled channel locations, one bit per channel |
| cfg_multi | input | 1 | Configuration word on the bus: 1 = multichannel conversion |
| cfg_inhibit | input | 1 | Configuration word on the bus: 1 = inhibit conversion |
| cfg_addr | input | AW | Configuration word on the bus: channel or memory address |
| mem_addr | output | AW | Pointer presented to the result memory |
| mem_rdata | input | DW | Result word read from the memory |
| dbus | output | DW | Tri-state data bus |
| dbus_oe | output | 1 | High while the block drives `dbus` |

## Verification
The bench builds the block with its defaults: eight channels and eight-bit results. This is the smallest case in which sparse masks such as channels 2, 5 and 7 can be set, in which a pointer can be loaded onto a location that is not enabled, and in which a wrap across the top index can happen. A full mask, a sparse mask and an empty mask are all applied. Because the memory is modelled in the bench with a distinct value for each location, every word driven on the bus identifies the location that was read.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    PA_HOLD    = 2'd0,
    PA_STEP    = 2'd1,
    PA_RESTART = 2'd2,
    PA_LOAD    = 2'd3
  } ptr_act_e;
endpackage

// File: rtl/rp_strobe_edge.sv
module rp_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  output logic act_begin,
  output logic act_end
);
  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= live;
  end

  assign act_begin = live && !live_q;
  assign act_end   = !live && live_q;
endmodule

// File: rtl/rp_action_dec.sv
module rp_action_dec
  import rp_pkg::*;
(
  input  logic     wr_begin,
  input  logic     wr_end,
  input  logic     rd_end,
  input  logic     cfg_multi,
  input  logic     cfg_inhibit,
  input  logic     pd,
  output ptr_act_e act
);
  always_comb begin
    act = PA_HOLD;
    if (wr_end && (cfg_inhibit || !cfg_multi))
      act = PA_LOAD;
    else if (wr_begin && cfg_multi && !cfg_inhibit && !pd)
      act = PA_RESTART;
    else if (rd_end && !pd)
      act = PA_STEP;
  end
endmodule

// File: rtl/rp_ptr_reg.sv
module rp_ptr_reg
  import rp_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ptr_act_e       act,
  input  logic [NCH-1:0] mask,
  input  logic [AW-1:0]  load_addr,
  output logic [AW-1:0]  ptr
);
  function automatic logic [AW-1:0] lowest_on(input logic [NCH-1:0] m);
    logic [AW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = AW'(i);
    return r;
  endfunction

  function automatic logic [AW-1:0] next_on(input logic [NCH-1:0] m,
                                            input logic [AW-1:0]  cur);
    logic [AW-1:0] r;
    logic          found;
    int            idx;
    r     = cur;
    found = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      idx = (int'(cur) + i) % NCH;
      if (!found && m[idx]) begin
        r     = AW'(idx);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else begin
      unique case (act)
        PA_STEP:    ptr <= next_on(mask, ptr);
        PA_RESTART: ptr <= lowest_on(mask);
        PA_LOAD:    ptr <= load_addr;
        default:    ptr <= ptr;
      endcase
    end
  end
endmodule

// File: rtl/rp_readback_ptr.sv
module rp_readback_ptr
  import rp_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic           pd,
  input  logic [NCH-1:0] chan_mask,
  input  logic           cfg_multi,
  input  logic           cfg_inhibit,
  input  logic [AW-1:0]  cfg_addr,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output wire  [DW-1:0]  dbus,
  output logic           dbus_oe
);
  logic     rd_live, wr_live;
  logic     rd_begin, rd_end, wr_begin, wr_end;
  ptr_act_e act;
  logic     ev_step, ev_restart, ev_load;

  assign rd_live = !cs_n && !rd_n && !pd;
  assign wr_live = !cs_n && !wr_n;

  rp_strobe_edge u_rd_edge (
    .clk(clk), .rst_n(rst_n), .live(rd_live),
    .act_begin(rd_begin), .act_end(rd_end)
  );

  rp_strobe_edge u_wr_edge (
    .clk(clk), .rst_n(rst_n), .live(wr_live),
    .act_begin(wr_begin), .act_end(wr_end)
  );

  rp_action_dec u_dec (
    .wr_begin(wr_begin), .wr_end(wr_end), .rd_end(rd_end),
    .cfg_multi(cfg_multi), .cfg_inhibit(cfg_inhibit), .pd(pd),
    .act(act)
  );

  rp_ptr_reg #(.NCH(NCH), .AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .act(act), .mask(chan_mask),
    .load_addr(cfg_addr), .ptr(mem_addr)
  );

  assign ev_step    = (act == PA_STEP);
  assign ev_restart = (act == PA_RESTART);
  assign ev_load    = (act == PA_LOAD);

  assign dbus_oe = rd_live;
  assign dbus    = dbus_oe ? mem_rdata : {DW{1'bz}};

  logic unused_rd_begin;
  assign unused_rd_begin = rd_begin;
endmodule

// File: rtl/rp_readback_ptr_chk.sv
module rp_readback_ptr_chk #(
  parameter int NCH = 8,
  parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           pd,
  input logic [NCH-1:0] chan_mask,
  input logic [AW-1:0]  cfg_addr,
  input logic [AW-1:0]  mem_addr,
  input logic           dbus_oe,
  input logic           ev_step,
  input logic           ev_restart,
  input logic           ev_load
);
  AST_PD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !dbus_oe); // R7

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dbus_oe); // R8

  AST_ADDR_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && $past(dbus_oe)) |-> $stable(mem_addr)); // R9

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (mem_addr == $past(cfg_addr))); // R5

  AST_STEP_LANDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && (chan_mask != '0)) |=> (chan_mask[mem_addr] || !$stable(chan_mask))); // R2

  AST_RESTART_LANDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_restart && (chan_mask != '0)) |=> (chan_mask[mem_addr] || !$stable(chan_mask))); // R4

  AST_IDLE_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_step && !ev_restart && !ev_load) |=> $stable(mem_addr)); // R8
endmodule

bind rp_readback_ptr rp_readback_ptr_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pd(pd), .chan_mask(chan_mask),
  .cfg_addr(cfg_addr), .mem_addr(mem_addr), .dbus_oe(dbus_oe),
  .ev_step(ev_step), .ev_restart(ev_restart), .ev_load(ev_load)
);

// File: tb/rp_readback_ptr_tb_top.sv
module rp_readback_ptr_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int AW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, pd = 1'b0;
  logic [NCH-1:0] chan_mask = '1;
  logic           cfg_multi = 1'b1, cfg_inhibit = 1'b0;
  logic [AW-1:0]  cfg_addr = '0;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_rdata;
  wire  [DW-1:0]  dbus;
  logic           dbus_oe;

  logic [DW-1:0] mem [NCH];
  int vectors = 0;
  int errors  = 0;
  int mptr    = 0;
  bit mrd = 0, mwr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  initial for (int i = 0; i < NCH; i++) mem[i] = DW'(8'h31 + i * 17);
  assign mem_rdata = mem[mem_addr];

  rp_readback_ptr #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .pd(pd),
    .chan_mask(chan_mask), .cfg_multi(cfg_multi), .cfg_inhibit(cfg_inhibit),
    .cfg_addr(cfg_addr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dbus(dbus), .dbus_oe(dbus_oe)
  );

  // Reference model: list of enabled channels, searched each step.
  always @(posedge clk) begin
    int en[$];
    int nxt;
    bit rd_now, wr_now;
    if (!rst_n) begin
      mptr = 0; mrd = 0; mwr = 0;
    end else begin
      en = {};
      for (int i = 0; i < NCH; i++) if (chan_mask[i]) en.push_back(i);
      rd_now = (cs_n == 0) && (rd_n == 0) && (pd == 0);
      wr_now = (cs_n == 0) && (wr_n == 0);
      if (mwr && !wr_now && (cfg_inhibit || !cfg_multi)) mptr = int'(cfg_addr);
      else if (!mwr && wr_now && cfg_multi && !cfg_inhibit && !pd)
        mptr = (en.size() > 0) ? en[0] : 0;
      else if (mrd && !rd_now && !pd && en.size() > 0) begin
        nxt = en[0];
        foreach (en[k]) if (en[k] > mptr) begin nxt = en[k]; break; end
        mptr = nxt;
      end
      mrd = rd_now; mwr = wr_now;
    end
  end

  // Per-clock comparison, sampled just before the next rising edge.
  always @(negedge clk) begin
    bit exp_oe;
    #3;
    if (rst_n && !done) begin
      exp_oe = (cs_n == 0) && (rd_n == 0) && (pd == 0);
      vectors++;
      if (int'(mem_addr) != mptr || dbus_oe != exp_oe ||
          (exp_oe && dbus != mem[mptr])) begin
        errors++;
        $display("FAIL R1,R9 model: addr=%0d oe=%0b bus=%h expected addr=%0d oe=%0b bus=%h",
                 mem_addr, dbus_oe, dbus, mptr, exp_oe, mem[mptr]);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_read(string req, int exp_loc);
    @(negedge clk); cs_n = 0; rd_n = 0;
    #2;
    check(req, int'(dbus_oe), 1);
    check(req, int'(dbus), int'(mem[exp_loc]));
    @(negedge clk); #2;
    check({req, " held"}, int'(mem_addr), exp_loc);
    @(negedge clk); rd_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic do_write(bit multi, bit inh, int addr);
    @(negedge clk); cfg_multi = multi; cfg_inhibit = inh; cfg_addr = AW'(addr);
    cs_n = 0; wr_n = 0;
    @(negedge clk); @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R10 oe", int'(dbus_oe), 0);
    check("R10 ptr", int'(mem_addr), 0);
    rst_n = 1;

    // R2/R3: full mask, eight reads then wrap
    chan_mask = 8'hFF;
    do_write(1, 0, 3);
    check("R4 restart full", int'(mem_addr), 0);
    for (int i = 0; i < 9; i++) do_read(i == 8 ? "R3 wrap full" : "R2 step", i % 8);

    // R4/R3: sparse mask 2,5,7
    chan_mask = 8'b1010_0100;
    do_write(1, 0, 0);
    check("R4 restart sparse", int'(mem_addr), 2);
    do_read("R4 first", 2); do_read("R2 sparse", 5);
    do_read("R2 sparse", 7); do_read("R3 wrap sparse", 2);

    // R5: inhibited load to a disabled location
    do_write(1, 1, 3);
    do_read("R5 loaded", 3); do_read("R5 continue", 5); do_read("R5 continue", 7);

    // R6: single-channel conversion
    do_write(0, 0, 6);
    do_read("R6 selected", 6); do_read("R6 older", 7); do_read("R6 older", 2);

    // R8: deselected strobes
    @(negedge clk); rd_n = 0; @(negedge clk); #2;
    check("R8 no drive", int'(dbus_oe), 0);
    @(negedge clk); rd_n = 1; wr_n = 0; cfg_multi = 1; cfg_inhibit = 0;
    @(negedge clk); wr_n = 1; @(negedge clk); #2;
    check("R8 ptr kept", int'(mem_addr), 5);
    do_read("R8 next read", 5);

    // R7: power-down
    pd = 1;
    @(negedge clk); cs_n = 0; rd_n = 0; @(negedge clk); #2;
    check("R7 no drive", int'(dbus_oe), 0);
    @(negedge clk); rd_n = 1; @(negedge clk); cs_n = 1; #2;
    check("R7 no step", int'(mem_addr), 7);
    do_write(1, 0, 0);
    check("R7 no restart", int'(mem_addr), 7);
    do_write(1, 1, 4);
    check("R7 load accepted", int'(mem_addr), 4);
    pd = 0;
    do_read("R7 after wake", 4);

    // R4: empty mask restarts to 0
    chan_mask = '0;
    do_write(1, 0, 6);
    check("R4 empty mask", int'(mem_addr), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule